// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block steers the datapath of a small multicycle load/store processor. A 4-bit state register walks each instruction through fetch, decode, effective-address calculation, memory access, ALU execution and register write-back, with short paths for conditional branch and unconditional jump. Each state drives one fixed word of datapath control points. That word is read from a 16-entry table indexed only by the state. A second table takes the state and the 6-bit opcode from the instruction register and gives the next state. Ten of the sixteen state codes are used.

The datapath holds the instruction register stable from decode until the instruction completes, and feeds its opcode field to this block. Any control point that a state does not name is driven low, so every output has an exact value in every cycle. An opcode that the block does not recognise, seen in decode, sends the sequencer back to fetch.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state after that edge is 0 (fetch).
- R2: State 0 drives pc_wr=1, mem_rd=1, ir_wr=1, alu_b=01 and all other controls 0. The next state is always 1.
- R3: State 1 (decode) drives alu_b=11 and all other controls 0. The next state is chosen by opcode: 0x23 or 0x2B gives 2, 0x00 gives 6, 0x04 gives 8, 0x02 gives 9, and any other opcode gives 0.
- R4: State 2 drives alu_a=1, alu_b=10 and all other controls 0. Opcode 0x23 gives next state 3, 0x2B gives 5, and any other opcode gives 0.
- R5: State 3 (load read) drives mem_rd=1 and addr_sel=1, all other controls 0. The next state is 4.
- R6: State 4 (load write-back) drives reg_wr=1, wb_sel=1, dst_sel=0 and all other controls 0. The next state is 0.
- R7: State 5 (store) drives mem_wr=1 and addr_sel=1, all other controls 0. The next state is 0.
- R8: State 6 drives alu_a=1, alu_b=00, alu_op=10 and goes to 7. State 7 drives reg_wr=1, dst_sel=1, wb_sel=0 and goes to 0. All other controls are 0 in both states.
- R9: State 8 (branch) drives alu_a=1, alu_op=01, pc_wr_cond=1, pc_sel=01 and all other controls 0. The next state is 0.
- R10: State 9 (jump) drives pc_wr=1, pc_sel=10 and all other controls 0. The next state is 0.
- R11: Control outputs depend only on the current state. Changing the opcode between clock edges leaves every control output unchanged.
- R12: After reset, the state output never exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when the ALU result is zero |
| addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| wb_sel | output | 1 | Register write data: 0 ALU result, 1 memory data |
| pc_sel | output | 2 | Next program counter: 00 ALU, 01 ALU result register, 10 jump target |
| alu_op | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| alu_b | output | 2 | ALU B operand: 00 register, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_a | output | 1 | ALU A operand: 0 program counter, 1 register |
| reg_wr | output | 1 | Register file write |
| dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |
| state_q | output | 4 | Current state code |

## Verification
A wrong next-state entry puts an unexpected code on `state_q` one cycle after the edge it came from. It also changes the whole control word in that same cycle, so a single bad dispatch shows at the ports within one clock. A corrupted output-table entry shows on the control pins as soon as the state is entered, even while `state_q` is still correct. Any dependence of the controls on the opcode shows as a control change between edges, before the next clock edge.

// File: rtl/mcf_pkg.sv
// Shared widths, state codes, opcodes and the control word layout for the
// multicycle control sequencer. Assumes a fixed 6-bit opcode field.
package mcf_pkg;
    localparam int STATE_W     = 4;
    localparam int OPC_W       = 6;
    localparam int TABLE_DEPTH = 1 << STATE_W;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [OPC_W-1:0]   opc_t;

    localparam state_t ST_FETCH  = 4'd0;
    localparam state_t ST_DECODE = 4'd1;
    localparam state_t ST_MADDR  = 4'd2;
    localparam state_t ST_LDMEM  = 4'd3;
    localparam state_t ST_LDWB   = 4'd4;
    localparam state_t ST_STMEM  = 4'd5;
    localparam state_t ST_EXEC   = 4'd6;
    localparam state_t ST_RDONE  = 4'd7;
    localparam state_t ST_BRANCH = 4'd8;
    localparam state_t ST_JUMP   = 4'd9;
    localparam state_t ST_LAST   = ST_JUMP;

    localparam opc_t OP_RTYPE = 6'h00;
    localparam opc_t OP_JMP   = 6'h02;
    localparam opc_t OP_BEQ   = 6'h04;
    localparam opc_t OP_LOAD  = 6'h23;
    localparam opc_t OP_STORE = 6'h2B;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_sel;
        logic [1:0] pc_sel;
        logic [1:0] alu_op;
        logic [1:0] alu_b;
        logic       alu_a;
        logic       reg_wr;
        logic       dst_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/mcf_state_reg.sv
// Current-state register. Assumes a synchronous active-low reset that
// forces the fetch state.
module mcf_state_reg
    import mcf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_t nxt,
    output state_t cur
);
    // Hold the state; load fetch on reset, else the next-state table output.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_FETCH;
        else        cur <= nxt;
    end

    // R1
    reset_to_fetch_chk: assert property (@(posedge clk) !rst_n |=> cur == ST_FETCH);
endmodule

// File: rtl/mcf_next_table.sv
// Next-state table indexed by current state and opcode. Unused state codes
// and unrecognised opcodes lead back to fetch. Assumes the opcode is stable
// from decode to instruction completion.
module mcf_next_table
    import mcf_pkg::*;
(
    input  state_t cur,
    input  opc_t   opc,
    output state_t nxt
);
    // Two-level lookup: state selects the row, opcode picks within dispatch rows.
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (opc)
                    OP_LOAD, OP_STORE: nxt = ST_MADDR;
                    OP_RTYPE:          nxt = ST_EXEC;
                    OP_BEQ:            nxt = ST_BRANCH;
                    OP_JMP:            nxt = ST_JUMP;
                    default:           nxt = ST_FETCH;
                endcase
            end
            ST_MADDR: begin
                case (opc)
                    OP_LOAD:  nxt = ST_LDMEM;
                    OP_STORE: nxt = ST_STMEM;
                    default:  nxt = ST_FETCH;
                endcase
            end
            ST_LDMEM:  nxt = ST_LDWB;
            ST_EXEC:   nxt = ST_RDONE;
            default:   nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcf_out_table.sv
// State-only output table: one control word per state code, built at
// elaboration. Unnamed controls and unused codes read as zero.
module mcf_out_table
    import mcf_pkg::*;
(
    input  state_t cur,
    output ctrl_t  ctrl
);
    // Control word for one state code.
    function automatic ctrl_t word_for(state_t s);
        ctrl_t w;
        w = '0;
        case (s)
            ST_FETCH:  begin w.pc_wr = 1'b1; w.mem_rd = 1'b1; w.ir_wr = 1'b1; w.alu_b = 2'b01; end
            ST_DECODE: begin w.alu_b = 2'b11; end
            ST_MADDR:  begin w.alu_a = 1'b1; w.alu_b = 2'b10; end
            ST_LDMEM:  begin w.mem_rd = 1'b1; w.addr_sel = 1'b1; end
            ST_LDWB:   begin w.reg_wr = 1'b1; w.wb_sel = 1'b1; end
            ST_STMEM:  begin w.mem_wr = 1'b1; w.addr_sel = 1'b1; end
            ST_EXEC:   begin w.alu_a = 1'b1; w.alu_op = 2'b10; end
            ST_RDONE:  begin w.reg_wr = 1'b1; w.dst_sel = 1'b1; end
            ST_BRANCH: begin w.alu_a = 1'b1; w.alu_op = 2'b01; w.pc_wr_cond = 1'b1; w.pc_sel = 2'b01; end
            ST_JUMP:   begin w.pc_wr = 1'b1; w.pc_sel = 2'b10; end
            default:   w = '0;
        endcase
        return w;
    endfunction

    logic [CTRL_W-1:0] rom [TABLE_DEPTH];

    for (genvar g = 0; g < TABLE_DEPTH; g++) begin : g_row
        assign rom[g] = word_for(state_t'(g));
    end

    // Read the word for the current state.
    assign ctrl = ctrl_t'(rom[cur]);
endmodule

// File: rtl/mc_ctrl_fsm.sv
// Moore control sequencer for a multicycle load/store datapath. Controls
// come from the state alone; only the next state looks at the opcode.
// Assumes the instruction register holds the opcode steady per instruction.
module mc_ctrl_fsm
    import mcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    output logic       pc_wr,
    output logic       pc_wr_cond,
    output logic       addr_sel,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic       ir_wr,
    output logic       wb_sel,
    output logic [1:0] pc_sel,
    output logic [1:0] alu_op,
    output logic [1:0] alu_b,
    output logic       alu_a,
    output logic       reg_wr,
    output logic       dst_sel,
    output logic [3:0] state_q
);
    state_t cur;
    state_t nxt;
    ctrl_t  ctrl;

    mcf_state_reg u_state (.clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(cur));
    mcf_next_table u_next (.cur(cur), .opc(opcode), .nxt(nxt));
    mcf_out_table u_out (.cur(cur), .ctrl(ctrl));

    // Fan the control word out to the datapath pins.
    assign pc_wr      = ctrl.pc_wr;
    assign pc_wr_cond = ctrl.pc_wr_cond;
    assign addr_sel   = ctrl.addr_sel;
    assign mem_rd     = ctrl.mem_rd;
    assign mem_wr     = ctrl.mem_wr;
    assign ir_wr      = ctrl.ir_wr;
    assign wb_sel     = ctrl.wb_sel;
    assign pc_sel     = ctrl.pc_sel;
    assign alu_op     = ctrl.alu_op;
    assign alu_b      = ctrl.alu_b;
    assign alu_a      = ctrl.alu_a;
    assign reg_wr     = ctrl.reg_wr;
    assign dst_sel    = ctrl.dst_sel;
    assign state_q    = cur;

    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur == ST_FETCH |=> cur == ST_DECODE);

    // R3
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_DECODE && opcode != OP_LOAD && opcode != OP_STORE && opcode != OP_RTYPE
         && opcode != OP_BEQ && opcode != OP_JMP) |=> (cur == ST_FETCH && ir_wr));

    // R5
    mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));

    // R8
    regwr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> ($past(cur) == ST_LDMEM || $past(cur) == ST_EXEC));

    // R9
    branch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |=> (cur == ST_FETCH && !pc_wr_cond));

    // R10
    jump_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == ST_DECODE && opcode == OP_JMP) |=> (pc_wr && pc_sel == 2'b10));

    // R12
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cur <= ST_LAST);
endmodule

// File: tb/tb_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module tb_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h00;
    logic       pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel;
    logic [1:0] pc_sel, alu_op, alu_b;
    logic       alu_a, reg_wr, dst_sel;
    logic [3:0] state_q;

    int total = 0;
    int bad = 0;
    logic [3:0] exp_st = 4'd0;

    always #2.5 clk = ~clk;

    mc_ctrl_fsm dut (.clk(clk), .rst_n(rst_n), .opcode(opcode), .pc_wr(pc_wr),
        .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_wr(ir_wr), .wb_sel(wb_sel), .pc_sel(pc_sel), .alu_op(alu_op), .alu_b(alu_b),
        .alu_a(alu_a), .reg_wr(reg_wr), .dst_sel(dst_sel), .state_q(state_q));

    function automatic logic [15:0] pins();
        return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_wr, wb_sel,
                pc_sel, alu_op, alu_b, alu_a, reg_wr, dst_sel};
    endfunction

    // Expected control word from the requirements, packed like pins().
    function automatic logic [15:0] ref_word(logic [3:0] s);
        logic pw = 0, pwc = 0, as = 0, mr = 0, mw = 0, iw = 0, ws = 0, aa = 0, rw = 0, ds = 0;
        logic [1:0] ps = 0, ao = 0, ab = 0;
        case (s)
            4'd0: begin pw = 1; mr = 1; iw = 1; ab = 2'b01; end
            4'd1: ab = 2'b11;
            4'd2: begin aa = 1; ab = 2'b10; end
            4'd3: begin mr = 1; as = 1; end
            4'd4: begin rw = 1; ws = 1; end
            4'd5: begin mw = 1; as = 1; end
            4'd6: begin aa = 1; ao = 2'b10; end
            4'd7: begin rw = 1; ds = 1; end
            4'd8: begin aa = 1; ao = 2'b01; pwc = 1; ps = 2'b01; end
            4'd9: begin pw = 1; ps = 2'b10; end
            default: ;
        endcase
        return {pw, pwc, as, mr, mw, iw, ws, ps, ao, ab, aa, rw, ds};
    endfunction

    function automatic logic [3:0] ref_next(logic [3:0] s, logic [5:0] op);
        case (s)
            4'd0: return 4'd1;
            4'd1: case (op)
                      6'h23, 6'h2B: return 4'd2;
                      6'h00: return 4'd6;
                      6'h04: return 4'd8;
                      6'h02: return 4'd9;
                      default: return 4'd0;
                  endcase
            4'd2: return (op == 6'h23) ? 4'd3 : (op == 6'h2B) ? 4'd5 : 4'd0;
            4'd3: return 4'd4;
            4'd6: return 4'd7;
            default: return 4'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] s);
        case (s)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6, 4'd7: return "R8";
            4'd8: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h state_exp=%0d", req, act, exp, exp_st);
        end
    endtask

    // Called at a falling edge: check, present the next opcode, advance the model.
    task automatic step(logic [5:0] op, logic do_rst);
        check(tag_of(exp_st), {12'h0, state_q}, {12'h0, exp_st});
        check(tag_of(exp_st), pins(), ref_word(exp_st));
        check("R12", {15'h0, (state_q > 4'd9)}, 16'h0);
        opcode = op;
        rst_n  = !do_rst;
        #1;
        check("R11", pins(), ref_word(exp_st));
        exp_st = do_rst ? 4'd0 : ref_next(exp_st, op);
        @(negedge clk);
    endtask

    task automatic run_instr(logic [5:0] op);
        do step(op, 1'b0); while (exp_st != 4'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset leaves the fetch state and its controls
        check("R1", {12'h0, state_q}, 16'h0);
        check("R1", pins(), ref_word(4'd0));
        rst_n = 1'b1;
        exp_st = 4'd0;
        run_instr(6'h23);
        run_instr(6'h2B);
        run_instr(6'h00);
        run_instr(6'h04);
        run_instr(6'h02);
        run_instr(6'h3F);           // R3: unknown opcode back to fetch
        step(6'h23, 0); step(6'h23, 0); step(6'h04, 0);   // R4: non-memory opcode
        step(6'h23, 0); step(6'h23, 0); step(6'h23, 0);   // now in state 3
        step(6'h11, 1);             // R1: reset mid-instruction
        check("R1", {12'h0, state_q}, 16'h0);
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] op;
            case ($urandom % 7)
                0: op = 6'h23;
                1: op = 6'h2B;
                2: op = 6'h00;
                3: op = 6'h04;
                4: op = 6'h02;
                default: op = 6'($urandom);
            endcase
            step(op, ($urandom % 250) == 0);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired R1 act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule